// File: doc/BRIEF.md
# GPIO controller with edge-event interrupts

This block manages 32 general-purpose pins behind a simple 32-bit register bus. Software uses a direction register to choose which pins it drives. Output values are held in an output latch. Input levels pass through a two-flop synchronizer. A single data offset returns, pin by pin, either the latched output value or the synchronized input level.

Each synchronized input is watched for edges. Software picks which edges are recorded for each pin. A recorded edge sets a sticky bit in an event register, and software clears that bit by writing a one to it. A mask register selects which pending events drive the single interrupt output.

The edge-control scheme is fixed when the block is built. In the one-bit scheme, each pin has one control bit that selects either falling edges only or both edges. In the two-bit scheme, each pin has a two-bit code, and the codes are spread across two registers. A second build option fixes a group of pins as inputs: either the top pin numbers or the bottom pin numbers.

Top module: `gpio_evt_ctrl`

## Requirements
- R1: Pin p sits at bit (31 − p) of every register, so pin 0 is the most significant bit. The register offsets are:
  - direction 0x00
  - data 0x08
  - event 0x0C
  - mask 0x10
  - edge control A 0x14
  - edge control B 0x18 (two-bit scheme only)

  Offset 0x18 in the one-bit scheme, and every other offset, reads 0.
- R2: A direction bit of 1 makes a pin an output. `pin_oe` equals the stored direction register, and `pin_out` equals the output latch written at 0x08.
- R3: A read of 0x08 returns the latch bit for output pins and the synchronized level for input pins.
- R4: A level change on `pin_in` appears in the event register after the third rising clock edge that follows it, and not after the second.
- R5: In the one-bit scheme, a control bit of 1 records only falling edges, and a control bit of 0 records both edges.
- R6: In the two-bit scheme:
  - Pins 0–15 take their code from register A and pins 16–31 from register B.
  - Pin p's code sits at bits [(15 − p mod 16)·2 +: 2].
  - Code 0 records both edges, code 1 records rising edges, code 2 records falling edges, and code 3 records nothing.
- R7: Writing a 1 to an event bit clears it. Writing a 0 leaves it unchanged.
- R8: When an edge on a pin coincides with a clearing write to that pin's event bit, the event stays set.
- R9: `irq` is high exactly when some event bit and its mask bit are both 1. The mask reads back at 0x10.
- R10: The input-only group consists of pins 28–31 (RO_HIGH_PINS) or pins 0–3 (RO_LOW_PINS). For those pins, direction bits read 0 and `pin_oe` is 0 whatever is written.
- R11: After reset, every register reads 0, and `irq` and `pin_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset for reads and writes |
| bus_wen | input | 1 | Write strobe; the write takes effect at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pin_in | input | 32 | Asynchronous pin levels, pin p on bit 31 − p |
| pin_out | output | 32 | Output latch value |
| pin_oe | output | 32 | Output enable per pin |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is an edge arriving in exactly the cycle that a write-one-to-clear hits the same event bit. Because of the synchronizer, the edge must be launched on `pin_in` two clock edges before the write strobe. The bench counts those edges explicitly and times the clearing write to land on the third edge. It then checks that the new event survives while an older event is cleared.

The edge schemes are covered by two instances built differently: one uses the one-bit scheme and the other the two-bit scheme. Each pin is swept individually, and every two-bit code is applied across all pins. For each case, the expected event word is computed arithmetically from the codes.

// File: rtl/gpev_pkg.sv
package gpev_pkg;
   localparam int DATA_W = 32;

   typedef enum logic { EDGE_ONEBIT = 1'b0, EDGE_TWOBIT = 1'b1 } edge_mode_e;
   typedef enum logic [1:0] { RO_NONE = 2'd0, RO_HIGH_PINS = 2'd1, RO_LOW_PINS = 2'd2 } ro_group_e;

   localparam logic [7:0] OFF_DIR   = 8'h00;
   localparam logic [7:0] OFF_DATA  = 8'h08;
   localparam logic [7:0] OFF_EVT   = 8'h0C;
   localparam logic [7:0] OFF_MASK  = 8'h10;
   localparam logic [7:0] OFF_CTL_A = 8'h14;
   localparam logic [7:0] OFF_CTL_B = 8'h18;

   localparam logic [1:0] CODE_BOTH = 2'd0;
   localparam logic [1:0] CODE_RISE = 2'd1;
   localparam logic [1:0] CODE_FALL = 2'd2;

   // Bit mask of pins that can never drive (pin p -> bit DATA_W-1-p)
   function automatic logic [DATA_W-1:0] ro_mask(ro_group_e grp, int cnt);
      logic [DATA_W-1:0] m;
      m = '0;
      for (int p = 0; p < DATA_W; p++) begin
         if ((grp == RO_HIGH_PINS && p >= DATA_W - cnt) || (grp == RO_LOW_PINS && p < cnt))
            m[DATA_W-1-p] = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/gpev_sync.sv
module gpev_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] q_out
);
   logic [STAGES-1:0][W-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q <= '0;
      end else begin
         stg_q[0] <= d_in;
         for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      end
   end

   assign q_out = stg_q[STAGES-1];
endmodule

// File: rtl/gpev_edge.sv
module gpev_edge import gpev_pkg::*; #(
   parameter int         W    = 32,
   parameter edge_mode_e MODE = EDGE_ONEBIT
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] ctl_a,
   input  logic [W-1:0] ctl_b,
   output logic [W-1:0] hit
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   if (MODE == EDGE_ONEBIT) begin : g_tie
      logic unused_ctl_b;
      assign unused_ctl_b = ^ctl_b;
   end

   for (genvar p = 0; p < W; p++) begin : g_pin
      localparam int B = W - 1 - p;
      logic rise, fall;
      assign rise = lvl[B] & ~prev_q[B];
      assign fall = ~lvl[B] & prev_q[B];

      if (MODE == EDGE_ONEBIT) begin : g_one
         assign hit[B] = fall | (rise & ~ctl_a[B]);
      end else begin : g_two
         localparam int SH = (15 - (p % 16)) * 2;
         logic [1:0] code;
         if (p < 16) begin : g_lo
            assign code = ctl_a[SH +: 2];
         end else begin : g_hi
            assign code = ctl_b[SH +: 2];
         end
         assign hit[B] = (code == CODE_BOTH) ? (rise | fall) :
                         (code == CODE_RISE) ? rise :
                         (code == CODE_FALL) ? fall : 1'b0;
      end
   end
endmodule

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl import gpev_pkg::*; #(
   parameter int         ADDR_W      = 8,
   parameter edge_mode_e EDGE_MODE   = EDGE_ONEBIT,
   parameter ro_group_e  RO_GROUP    = RO_HIGH_PINS,
   parameter int         RO_COUNT    = 4,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wen,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [31:0]       pin_in,
   output logic [31:0]       pin_out,
   output logic [31:0]       pin_oe,
   output logic              irq
);
   localparam int           W       = DATA_W;
   localparam logic [W-1:0] RO_MASK = ro_mask(RO_GROUP, RO_COUNT);

   if (ADDR_W < 5) begin : g_chk_addr
      $error("ADDR_W must cover offset 0x18");
   end
   if (RO_COUNT < 0 || RO_COUNT > 16) begin : g_chk_ro
      $error("RO_COUNT out of range");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [W-1:0] dir_q, lat_q, evt_q, msk_q, ctl_a_q, ctl_b_q;
   logic [W-1:0] lvl_sync, hit_vec, clr_vec, ro_vec;
   logic         wr_dir, wr_data, wr_evt, wr_mask, wr_ctl_a, wr_ctl_b;

   assign wr_dir   = bus_wen && (bus_addr == ADDR_W'(OFF_DIR));
   assign wr_data  = bus_wen && (bus_addr == ADDR_W'(OFF_DATA));
   assign wr_evt   = bus_wen && (bus_addr == ADDR_W'(OFF_EVT));
   assign wr_mask  = bus_wen && (bus_addr == ADDR_W'(OFF_MASK));
   assign wr_ctl_a = bus_wen && (bus_addr == ADDR_W'(OFF_CTL_A));
   assign wr_ctl_b = bus_wen && (bus_addr == ADDR_W'(OFF_CTL_B));
   assign clr_vec  = wr_evt ? bus_wdata : '0;
   assign ro_vec   = RO_MASK;

   gpev_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (pin_in),
      .q_out (lvl_sync)
   );

   gpev_edge #(.W(W), .MODE(EDGE_MODE)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (lvl_sync),
      .ctl_a (ctl_a_q),
      .ctl_b (ctl_b_q),
      .hit   (hit_vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= '0;
         lat_q   <= '0;
         evt_q   <= '0;
         msk_q   <= '0;
         ctl_a_q <= '0;
      end else begin
         if (wr_dir)   dir_q   <= bus_wdata & ~RO_MASK;
         if (wr_data)  lat_q   <= bus_wdata;
         if (wr_mask)  msk_q   <= bus_wdata;
         if (wr_ctl_a) ctl_a_q <= bus_wdata;
         // new edges take priority over a same-cycle clear
         evt_q <= (evt_q & ~clr_vec) | hit_vec;
      end
   end

   if (EDGE_MODE == EDGE_TWOBIT) begin : g_ctl_b
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        ctl_b_q <= '0;
         else if (wr_ctl_b) ctl_b_q <= bus_wdata;
      end
   end else begin : g_no_ctl_b
      logic unused_wr_b;
      assign unused_wr_b = wr_ctl_b;
      assign ctl_b_q     = '0;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFF_DIR))   bus_rdata = dir_q;
      if (bus_addr == ADDR_W'(OFF_DATA))  bus_rdata = (dir_q & lat_q) | (~dir_q & lvl_sync);
      if (bus_addr == ADDR_W'(OFF_EVT))   bus_rdata = evt_q;
      if (bus_addr == ADDR_W'(OFF_MASK))  bus_rdata = msk_q;
      if (bus_addr == ADDR_W'(OFF_CTL_A)) bus_rdata = ctl_a_q;
      if (bus_addr == ADDR_W'(OFF_CTL_B)) bus_rdata = ctl_b_q;
   end

   assign pin_out = lat_q;
   assign pin_oe  = dir_q;
   assign irq     = |(evt_q & msk_q);
endmodule

// File: rtl/gpev_chk.sv
module gpev_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         irq,
   input logic [W-1:0] pin_oe,
   input logic [W-1:0] ro_vec,
   input logic [W-1:0] evt_q,
   input logic [W-1:0] msk_q,
   input logic [W-1:0] clr_vec,
   input logic [W-1:0] hit_vec
);
   // R10
   ro_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe & ro_vec) == '0);

   // R9
   irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msk_q == '0) |-> !irq);

   // R7
   evt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(evt_q & ~clr_vec) & ~evt_q) == '0));

   // R7
   evt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec != '0) |=> ((evt_q & $past(clr_vec & ~hit_vec)) == '0));

   // R8
   edge_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(hit_vec) & ~evt_q) == '0));
endmodule

bind gpio_evt_ctrl gpev_chk #(.W(32)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .irq     (irq),
   .pin_oe  (pin_oe),
   .ro_vec  (ro_vec),
   .evt_q   (evt_q),
   .msk_q   (msk_q),
   .clr_vec (clr_vec),
   .hit_vec (hit_vec)
);

// File: tb/gpio_evt_ctrl_tb.sv
module gpio_evt_ctrl_tb;
   import gpev_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [1:0]  wen = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] pins = '0;
   logic [31:0] rdata0, rdata1, pout0, pout1, poe0, poe1;
   logic        irq0, irq1;
   int          checks = 0;
   int          failures = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   // one-bit scheme, pins 0..3 input-only (bits 31:28)
   gpio_evt_ctrl #(.EDGE_MODE(EDGE_ONEBIT), .RO_GROUP(RO_LOW_PINS)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(wen[0]), .bus_wdata(bus_wdata),
      .bus_rdata(rdata0), .pin_in(pins), .pin_out(pout0), .pin_oe(poe0), .irq(irq0));

   // two-bit scheme, pins 28..31 input-only (bits 3:0)
   gpio_evt_ctrl #(.EDGE_MODE(EDGE_TWOBIT), .RO_GROUP(RO_HIGH_PINS)) u_dut1 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(wen[1]), .bus_wdata(bus_wdata),
      .bus_rdata(rdata1), .pin_in(pins), .pin_out(pout1), .pin_oe(poe1), .irq(irq1));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int d, input logic [7:0] a, input logic [31:0] v);
      @(negedge clk);
      bus_addr = a; bus_wdata = v; wen[d] = 1'b1;
      @(negedge clk);
      wen = '0;
   endtask

   task automatic rd(input int d, input logic [7:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_addr = a;
      #1;
      v = (d == 0) ? rdata0 : rdata1;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   initial begin
      logic [31:0] v, ca, cb, er, ef, dexp;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      for (int a = 0; a < 8; a++) begin
         rd(0, 8'(a * 4), v); chk("R11 dut0 reg", v, 32'h0);
         rd(1, 8'(a * 4), v); chk("R11 dut1 reg", v, 32'h0);
      end
      chk("R11 irq", {30'd0, irq1, irq0}, 32'h0);
      chk("R11 oe", poe0 | poe1, 32'h0);

      // R1 / R5 per-pin sweep, both-edge control
      for (int p = 0; p < 32; p++) begin
         pins = 32'h1 << (31 - p);
         settle();
         rd(0, OFF_EVT, v); chk("R1 rise bit", v, 32'h1 << (31 - p));
         pins = '0;
         settle();
         rd(0, OFF_EVT, v); chk("R5 both edges", v, 32'h1 << (31 - p));
         wr(0, OFF_EVT, 32'hFFFF_FFFF);
         rd(0, OFF_EVT, v); chk("R7 clear all", v, 32'h0);
      end

      // R5 falling-only for pins 0..15
      wr(0, OFF_CTL_A, 32'hFFFF_0000);
      pins = 32'hFFFF_FFFF; settle();
      rd(0, OFF_EVT, v); chk("R5 rise masked", v, 32'h0000_FFFF);
      wr(0, OFF_EVT, 32'hFFFF_FFFF);
      pins = 32'h0; settle();
      rd(0, OFF_EVT, v); chk("R5 fall", v, 32'hFFFF_FFFF);
      wr(0, OFF_EVT, 32'hFFFF_FFFF);

      // R6 two-bit codes, pin p uses code p%4
      ca = '0; cb = '0; er = '0; ef = '0;
      for (int p = 0; p < 32; p++) begin
         int sh = (15 - (p % 16)) * 2;
         int c = p % 4;
         if (p < 16) ca |= 32'(c) << sh; else cb |= 32'(c) << sh;
         if (c == 0 || c == 1) er |= 32'h1 << (31 - p);
         if (c == 0 || c == 2) ef |= 32'h1 << (31 - p);
      end
      wr(1, OFF_CTL_A, ca); wr(1, OFF_CTL_B, cb);
      rd(1, OFF_CTL_A, v); chk("R6 ctl A readback", v, ca);
      rd(1, OFF_CTL_B, v); chk("R6 ctl B readback", v, cb);
      wr(1, OFF_EVT, 32'hFFFF_FFFF);
      pins = 32'hFFFF_FFFF; settle();
      rd(1, OFF_EVT, v); chk("R6 rise codes", v, er);
      wr(1, OFF_EVT, 32'hFFFF_FFFF);
      pins = 32'h0; settle();
      rd(1, OFF_EVT, v); chk("R6 fall codes", v, ef);
      wr(1, OFF_EVT, 32'hFFFF_FFFF);
      wr(0, OFF_EVT, 32'hFFFF_FFFF);

      // R4 latency on pin 20 (bit 11), both edges
      @(negedge clk);
      bus_addr = OFF_EVT;
      pins = 32'h0000_0800;
      @(posedge clk); #1; chk("R4 edge1", rdata0, 32'h0);
      @(posedge clk); #1; chk("R4 edge2", rdata0, 32'h0);
      @(posedge clk); #1; chk("R4 edge3", rdata0, 32'h0000_0800);

      // R7 partial clear: pin 21 (bit 10)
      pins = 32'h0000_0C00; settle();
      wr(0, OFF_EVT, 32'h0000_0800);
      rd(0, OFF_EVT, v); chk("R7 partial clear", v, 32'h0000_0400);
      wr(0, OFF_EVT, 32'h0);
      rd(0, OFF_EVT, v); chk("R7 zero write", v, 32'h0000_0400);

      // R8 edge on pin 22 (bit 9) meets clear-all in the same cycle
      @(negedge clk);
      pins = 32'h0000_0E00;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      bus_addr = OFF_EVT; bus_wdata = 32'hFFFF_FFFF; wen[0] = 1'b1;
      @(negedge clk);
      wen = '0;
      rd(0, OFF_EVT, v); chk("R8 edge wins", v, 32'h0000_0200);

      // R9 interrupt masking
      chk("R9 masked", {31'd0, irq0}, 32'h0);
      wr(0, OFF_MASK, 32'h0000_0200);
      rd(0, OFF_MASK, v); chk("R9 mask readback", v, 32'h0000_0200);
      chk("R9 unmasked", {31'd0, irq0}, 32'h1);
      wr(0, OFF_MASK, 32'hFFFF_FDFF);
      chk("R9 other bits", {31'd0, irq0}, 32'h0);
      wr(0, OFF_MASK, 32'hFFFF_FFFF);
      wr(0, OFF_EVT, 32'hFFFF_FFFF);
      chk("R9 cleared", {31'd0, irq0}, 32'h0);

      // R10 / R2 / R3 direction and data
      wr(0, OFF_DIR, 32'hFFFF_0000);
      rd(0, OFF_DIR, v); chk("R10 low group dir", v, 32'h0FFF_0000);
      chk("R2 oe", poe0, 32'h0FFF_0000);
      wr(0, OFF_DATA, 32'hA5A5_A5A5);
      chk("R2 pin_out", pout0, 32'hA5A5_A5A5);
      pins = 32'h3C3C_3C3C; settle();
      dexp = (32'h0FFF_0000 & 32'hA5A5_A5A5) | (~32'h0FFF_0000 & 32'h3C3C_3C3C);
      rd(0, OFF_DATA, v); chk("R3 data mix", v, dexp);
      wr(1, OFF_DIR, 32'hFFFF_FFFF);
      rd(1, OFF_DIR, v); chk("R10 high group dir", v, 32'hFFFF_FFF0);
      chk("R10 high group oe", poe1, 32'hFFFF_FFF0);
      wr(1, OFF_DATA, 32'h0000_00FF);
      rd(1, OFF_DATA, v);
      chk("R3 data mix dut1", v, (32'hFFFF_FFF0 & 32'h0000_00FF) | (32'h0000_000F & 32'h3C3C_3C3C));

      // R1 undefined offsets
      rd(0, 8'h04, v); chk("R1 offset 04", v, 32'h0);
      rd(0, 8'h18, v); chk("R1 offset 18 one-bit", v, 32'h0);
      rd(0, 8'h1C, v); chk("R1 offset 1C", v, 32'h0);
      rd(1, 8'h20, v); chk("R1 offset 20", v, 32'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule